// File: doc/BRIEF.md
# Dual-Lane Interleaving Pixel Streamer

This block sends one display line out of a single byte-wide output register, fed by two transfer lanes that take turns. The line buffer is stored rearranged. All pixels in odd display positions (counting from 1) are stored first, in order, in one contiguous run. All even-position pixels follow in a second run. Lane A walks the odd run and lane B walks the even run. Each lane can only step its address by one, so interleaving the two lanes one byte at a time restores the displayed order.

Software or a line sequencer loads a base address and a byte count for each lane with a single `start` pulse. A shared pacing input then moves one byte per asserted cycle. Transfers follow a round-robin grant:
- Lane A always goes first.
- While both lanes still hold bytes, the grant alternates between them on every transfer.
- When one lane runs out, the other lane continues alone until it is empty.
- When the last byte is written, a done pulse is issued.

Memory is read through a combinational read port: the address and data appear in the same cycle, and the data byte is captured into the output register.

Top module: `twin_lane_streamer`

## Requirements
- R1: A `start` pulse while `busy` is low loads both lanes' base and count. `busy` is high from the cycle after `start` when either count is non-zero. A `start` while `busy` is high is ignored, and the line in progress continues unchanged.
- R2: Each cycle with `pace` high while `busy` is high moves exactly one byte. In that case `pix_valid` is high in the following cycle only. With `busy` low, `pace` produces no output.
- R3: The first byte of every line comes from lane A (`pix_lane` = 0) whenever lane A's count is non-zero. This holds wherever the two lanes' bases lie in memory.
- R4: While both lanes still hold bytes, consecutive transfers alternate lanes (`pix_lane` 0 = lane A, 1 = lane B).
- R5: A lane's k-th transfer (k from 0) reads address base+k. `pix_data` equals the memory byte at that address.
- R6: Once one lane's count reaches zero, every further transfer comes from the other lane until its count also reaches zero.
- R7: `done` is high for one cycle, together with the `pix_valid` of the last byte of the line. At that time `busy` is already low and exactly a_len+b_len bytes have been output.
- R8: A `start` with both counts zero makes `done` high in the cycle after `start`. In that case no `pix_valid` is produced and `busy` stays low.
- R9: With lane A given the first ceil(n/2) bytes and lane B the next floor(n/2) bytes of an n-pixel rearranged line, the output sequence equals display positions 1..n in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a line (accepted only when idle) |
| a_base | input | AW | Lane A first byte address |
| a_len | input | LW | Lane A byte count |
| b_base | input | AW | Lane B first byte address |
| b_len | input | LW | Lane B byte count |
| pace | input | 1 | Pacing trigger: one byte per high cycle |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | AW | Memory read address |
| rd_data | input | DW | Memory read data (same cycle) |
| pix_data | output | DW | Output pixel register |
| pix_valid | output | 1 | New pixel in `pix_data` this cycle |
| pix_lane | output | 1 | Lane that wrote the pixel (0 = A, 1 = B) |
| busy | output | 1 | A line is in progress |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench sweeps every pair of lane counts from 0 to 5, under both continuous and gapped pacing. Lane B's run is placed below lane A's in memory, so a grant that followed address order would put lane B first. Unequal counts check that the longer lane continues alone: a design that kept alternating would issue a read from an empty lane, and one that stopped early would end short. The zero-count line and the end-of-line pulse are checked for an off-by-one cycle. A `start` injected mid-line checks that a design that reloaded would output the wrong bytes. Rearranged lines of 1 to 9 pixels are compared against display order.

// File: rtl/tl_pkg.sv
package tl_pkg;
   typedef enum logic {
      LANE_A = 1'b0,
      LANE_B = 1'b1
   } lane_e;

   localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/lane_cursor.sv
module lane_cursor #(
   parameter int unsigned AW = 16,
   parameter int unsigned LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] len,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          active,
   output logic          last
);
   localparam logic [AW-1:0] ADDR_ONE = AW'(1);
   localparam logic [LW-1:0] CNT_ONE  = LW'(1);

   logic [AW-1:0] ptr_q;
   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         ptr_q <= base;
         cnt_q <= len;
      end else if (step) begin
         ptr_q <= ptr_q + ADDR_ONE;
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign addr   = ptr_q;
   assign active = (cnt_q != '0);
   assign last   = (cnt_q == CNT_ONE);

   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> active);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr == $past(addr) + ADDR_ONE));
endmodule

// File: rtl/rr_pick.sv
module rr_pick
   import tl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [1:0] act,
   input  logic       fire,
   output lane_e      sel
);
   lane_e grant_q;

   always_comb begin
      if (grant_q == LANE_A) sel = act[0] ? LANE_A : LANE_B;
      else                   sel = act[1] ? LANE_B : LANE_A;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       grant_q <= LANE_A;
      else if (restart) grant_q <= LANE_A;
      else if (fire)    grant_q <= (sel == LANE_A) ? LANE_B : LANE_A;
   end

   // R6
   sel_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> ((sel == LANE_A) ? act[0] : act[1]));
endmodule

// File: rtl/out_stage.sv
module out_stage
   import tl_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  lane_e         sel,
   input  logic [DW-1:0] rd_data,
   input  logic          fin,
   output logic [DW-1:0] pix_data,
   output logic          pix_valid,
   output logic          pix_lane,
   output logic          done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_data  <= '0;
         pix_valid <= 1'b0;
         pix_lane  <= 1'b0;
         done      <= 1'b0;
      end else begin
         pix_valid <= fire;
         done      <= fin;
         if (fire) begin
            pix_data <= rd_data;
            pix_lane <= (sel == LANE_B);
         end
      end
   end

   // R2
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> $past(fire));
endmodule

// File: rtl/twin_lane_streamer.sv
module twin_lane_streamer
   import tl_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 16,
   parameter int unsigned LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] a_base,
   input  logic [LW-1:0] a_len,
   input  logic [AW-1:0] b_base,
   input  logic [LW-1:0] b_len,
   input  logic          pace,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic [DW-1:0] pix_data,
   output logic          pix_valid,
   output logic          pix_lane,
   output logic          busy,
   output logic          done
);
   initial begin
      param_chk: assert (DW >= 1 && AW >= 2 && LW >= 1 && LW <= AW + 1)
         else $error("twin_lane_streamer: bad width parameters");
   end

   logic [AW-1:0] base_v [NUM_LANES];
   logic [LW-1:0] len_v  [NUM_LANES];
   logic [AW-1:0] addr_v [NUM_LANES];
   logic [1:0]    act;
   logic [1:0]    last;
   logic [1:0]    step;
   lane_e         sel;
   logic          start_ok;
   logic          fire;
   logic          fin;

   assign base_v[0] = a_base;
   assign base_v[1] = b_base;
   assign len_v[0]  = a_len;
   assign len_v[1]  = b_len;

   assign busy     = |act;
   assign start_ok = start & ~busy;
   assign fire     = pace & busy;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      assign step[g] = fire && (sel == lane_e'(g));
      lane_cursor #(.AW(AW), .LW(LW)) u_cur (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (start_ok),
         .base   (base_v[g]),
         .len    (len_v[g]),
         .step   (step[g]),
         .addr   (addr_v[g]),
         .active (act[g]),
         .last   (last[g])
      );
   end

   rr_pick u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_ok),
      .act     (act),
      .fire    (fire),
      .sel     (sel)
   );

   assign rd_en   = fire;
   assign rd_addr = (sel == LANE_B) ? addr_v[1] : addr_v[0];

   always_comb begin
      if (sel == LANE_B) fin = fire && last[1] && !act[0];
      else               fin = fire && last[0] && !act[1];
      if (start_ok && a_len == '0 && b_len == '0) fin = 1'b1;
   end

   out_stage #(.DW(DW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .sel       (sel),
      .rd_data   (rd_data),
      .fin       (fin),
      .pix_data  (pix_data),
      .pix_valid (pix_valid),
      .pix_lane  (pix_lane),
      .done      (done)
   );

   logic  moved_q;
   lane_e prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         moved_q <= 1'b0;
         prev_q  <= LANE_A;
      end else if (start_ok) begin
         moved_q <= 1'b0;
      end else if (fire) begin
         moved_q <= 1'b1;
         prev_q  <= sel;
      end
   end

   // R3
   first_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !moved_q && act[0]) |-> (sel == LANE_A));

   // R4
   alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && moved_q && act == 2'b11) |-> (sel != prev_q));

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R1
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fire) |=> busy);
endmodule

// File: tb/twin_lane_streamer_test.sv
`timescale 1ns/1ps
module twin_lane_streamer_test;
   localparam int DW = 8;
   localparam int AW = 10;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] a_base = '0, b_base = '0;
   logic [LW-1:0] a_len = '0, b_len = '0;
   logic          pace = 1'b0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;
   logic [DW-1:0] pix_data;
   logic          pix_valid, pix_lane, busy, done;

   int n_chk = 0;
   int n_bad = 0;
   int exp_v [32];
   int exp_l [32];

   always #2.5 clk = ~clk;

   function automatic int memf(int a);
      return (a * 37 + 11) & 255;
   endfunction

   assign rd_data = DW'(memf(int'(rd_addr)));

   twin_lane_streamer #(.DW(DW), .AW(AW), .LW(LW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_base(a_base), .a_len(a_len), .b_base(b_base), .b_len(b_len),
      .pace(pace), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .pix_data(pix_data), .pix_valid(pix_valid), .pix_lane(pix_lane),
      .busy(busy), .done(done)
   );

   task automatic chk(bit ok, string tag, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic build_rr(int la, int lb, int ba, int bb);
      int ia = 0, ib = 0, turn = 0;
      for (int k = 0; k < la + lb; k++) begin
         if (ia < la && (turn == 0 || ib >= lb)) begin
            exp_v[k] = memf(ba + ia); exp_l[k] = 0; ia++; turn = 1;
         end else begin
            exp_v[k] = memf(bb + ib); exp_l[k] = 1; ib++; turn = 0;
         end
      end
   endtask

   task automatic build_disp(int n, int ba, int bb);
      for (int p = 1; p <= n; p++) begin
         if (p % 2 == 1) begin exp_v[p-1] = memf(ba + (p - 1) / 2); exp_l[p-1] = 0; end
         else            begin exp_v[p-1] = memf(bb + p / 2 - 1);   exp_l[p-1] = 1; end
      end
   endtask

   task automatic run_line(int la, int lb, int ba, int bb, int mode, bit poke, bit disp);
      int idx = 0, cyc = 0, tot = la + lb;
      bit poked = 0, applied;
      if (disp) build_disp(tot, ba, bb); else build_rr(la, lb, ba, bb);
      @(negedge clk);
      a_base = AW'(ba); b_base = AW'(bb); a_len = LW'(la); b_len = LW'(lb);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == (tot > 0), "R1 busy after start", int'(busy), int'(tot > 0));
      if (tot == 0) begin
         chk(done == 1'b1, "R8 done on empty line", int'(done), 1);
         chk(pix_valid == 1'b0, "R8 no pixel on empty line", int'(pix_valid), 0);
         @(negedge clk);
         chk(done == 1'b0 && busy == 1'b0, "R8 single pulse", int'(done), 0);
         return;
      end
      while (1) begin
         if (poke && idx == 2 && !poked) begin
            a_base = AW'(900); b_base = AW'(950); a_len = LW'(7); b_len = LW'(7);
            start = 1'b1; pace = 1'b0; poked = 1;
         end else begin
            pace = (mode == 0) ? 1'b1 : ((cyc % 2) == 0);
         end
         applied = pace;
         @(negedge clk);
         start = 1'b0;
         if (idx < tot)
            chk(pix_valid == applied, "R2 one byte per pace", int'(pix_valid), int'(applied));
         if (pix_valid && idx < tot) begin
            chk(int'(pix_lane) == exp_l[idx],
                idx == 0 ? "R3 first lane" : "R4/R6 lane order", int'(pix_lane), exp_l[idx]);
            chk(int'(pix_data) == exp_v[idx],
                disp ? "R9 display order" : (poked ? "R1 start ignored" : "R5 data"),
                int'(pix_data), exp_v[idx]);
            idx++;
         end
         if (done) begin
            chk(idx == tot && busy == 1'b0, "R7 done at last byte", idx, tot);
            break;
         end
         cyc++;
         if (cyc > 200) begin
            chk(1'b0, "R7 line never finished", idx, tot);
            break;
         end
      end
      pace = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R7 done is one cycle", int'(done), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && pix_valid == 1'b0 && done == 1'b0, "R1 reset idle",
          int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: pace with no line active produces nothing
      pace = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(pix_valid == 1'b0, "R2 idle pace ignored", int'(pix_valid), 0);
      end
      pace = 1'b0;
      // sweep of lane counts; lane B stored below lane A in memory
      for (int mode = 0; mode < 2; mode++)
         for (int la = 0; la <= 5; la++)
            for (int lb = 0; lb <= 5; lb++)
               run_line(la, lb, 120 + la * 3, 20 + lb, mode, 1'b0, 1'b0);
      // R1: start while busy must not disturb the line
      run_line(3, 3, 10, 50, 0, 1'b1, 1'b0);
      run_line(4, 2, 600, 300, 1, 1'b1, 1'b0);
      // R9: rearranged lines compared to display order
      for (int n = 1; n <= 9; n++)
         run_line((n + 1) / 2, n / 2, 300, 300 + (n + 1) / 2, n % 2, 1'b0, 1'b1);
      // R2: idle again after lines
      pace = 1'b1;
      @(negedge clk);
      chk(pix_valid == 1'b0, "R2 idle pace after lines", int'(pix_valid), 0);
      pace = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule